// File: doc/BRIEF.md
# Parallel-Port Bridge Register Access Engine

This block is the host-side engine that reads or writes one register of an IDE device sitting behind a parallel-to-IDE bridge chip. The host logic gives it a single command: read or write, nibble or byte transfer mode, a bank bit (task-file registers or control/command set), a 3-bit register index and, for writes, a data byte. The engine then drives the port's data and control lines through a fixed series of steps. Each step is held for a parameterized number of clock cycles so that a slow bridge sees stable levels.

Every access starts with the same addressing preamble. This preamble wraps the computed address byte in select and latch handshakes. A write then presents the value twice, and each copy is followed by a latch handshake. In nibble mode a read takes two status-line samples and joins their upper halves into one byte. In byte mode a read turns the data lines around and samples them directly. When the last step ends, a one-cycle done pulse is issued. The read byte stays on its output until a later read replaces it.

Top module: `bre_engine`

## Requirements
- R1: The address byte is reg_idx*4 + 1 + cont. With cont=0 it selects the task-file bank and with cont=1 the command bank, giving values 1..30.
- R2: Each select handshake drives the control lines with 0x05, 0x0D, 0x05, 0x0D, 0x05, 0x04, in that order.
- R3: Each latch handshake drives the control lines with 0x05, 0x07, 0x05, 0x04, in that order.
- R4: Every access begins with these 19 steps: data 0x01, a select handshake, data = address byte, a latch handshake, data 0x00, a select handshake.
- R5: A write (wr=1) continues with data = wdata and a latch handshake, then data = wdata again and a second latch handshake. The data lines stay driven (pd_oe=1) for the whole access.
- R6: A nibble-mode read (byte_mode=0) continues with control steps 0x06, [sample A from ps_in], 0x04, 0x06, [sample B from ps_in], 0x04, 0x06, 0x04, 0x06, 0x04. The result is {B[7:4], A[7:4]}.
- R7: A byte-mode read (byte_mode=1) continues with control steps 0x26, [sample pd_in], 0x04, 0x26, 0x04, and the sampled byte is the result. pd_oe equals the inverse of control bit 5, so the data lines are released whenever control is 0x26.
- R8: Every step, sample steps included, lasts exactly HOLD cycles. done is a one-cycle pulse that rises N*HOLD cycles after the edge that accepts start. N is 29 for writes and nibble reads, and 24 for byte reads.
- R9: rd_data is registered. It is unchanged by writes and while idle, and it stays valid from done until a later read samples again. A start pulse while an access is running is ignored.
- R10: After reset: pc_out=0x04, pd_out=0x00, pd_oe=1, done=0, rd_data=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an access (accepted only when idle) |
| wr | input | 1 | 1 = write, 0 = read |
| byte_mode | input | 1 | 0 = nibble transfers, 1 = byte transfers |
| cont | input | 1 | Bank select: 0 task file, 1 command set |
| reg_idx | input | 3 | Register index within the bank |
| wdata | input | 8 | Byte to write |
| ps_in | input | 8 | Port status lines |
| pd_in | input | 8 | Port data lines as read back |
| pd_out | output | 8 | Port data drive value |
| pd_oe | output | 1 | Data line drive enable |
| pc_out | output | 8 | Port control drive value |
| rd_data | output | 8 | Read result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check on every cycle the properties that hold independently of any particular command. Port levels must not move between step boundaries. The step counter never passes HOLD-1. Control stays within its legal value set. Writes never release the data lines. done is a lone pulse that comes only out of an active access. The result is frozen while the engine is idle. The exact step orderings, the address arithmetic, the nibble joining of two status samples, the cycle on which done appears, and the rejection of a start that arrives mid-access all depend on the command. Only the bench's scenarios show these, because they compare the full port trace against a separately built expectation.

// File: rtl/bre_pkg.sv
package bre_pkg;

  typedef enum logic [2:0] {
    OP_DATA,
    OP_CTRL,
    OP_SAMP_A,
    OP_SAMP_B,
    OP_SAMP_D
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] val;
    logic       last;
  } step_t;

  localparam int PRE_STEPS = 19;

  function automatic logic [7:0] addr_byte(logic cont, logic [2:0] idx);
    return {3'b000, idx, 2'b00} + 8'd1 + {7'd0, cont};
  endfunction

  function automatic logic [7:0] nib_join(logic [7:0] a, logic [7:0] b);
    return {b[7:4], a[7:4]};
  endfunction

  function automatic logic [7:0] sel_val(int k);
    case (k)
      0, 2, 4: return 8'h05;
      1, 3:    return 8'h0d;
      default: return 8'h04;
    endcase
  endfunction

  function automatic logic [7:0] lat_val(int k);
    case (k)
      0, 2:    return 8'h05;
      1:       return 8'h07;
      default: return 8'h04;
    endcase
  endfunction

  function automatic step_t mk(op_e op, logic [7:0] v, logic l);
    step_t s;
    s.op = op;
    s.val = v;
    s.last = l;
    return s;
  endfunction

  // Step table: shared preamble then a tail picked by direction and mode.
  function automatic step_t step_at(logic [4:0] i, logic wr, logic bm,
                                    logic [7:0] adr, logic [7:0] wd);
    int k = int'(i);
    int t = k - PRE_STEPS;
    if (k == 0)       return mk(OP_DATA, 8'h01, 1'b0);
    else if (k <= 6)  return mk(OP_CTRL, sel_val(k - 1), 1'b0);
    else if (k == 7)  return mk(OP_DATA, adr, 1'b0);
    else if (k <= 11) return mk(OP_CTRL, lat_val(k - 8), 1'b0);
    else if (k == 12) return mk(OP_DATA, 8'h00, 1'b0);
    else if (k <= 18) return mk(OP_CTRL, sel_val(k - 13), 1'b0);
    else if (wr) begin
      if (t == 0 || t == 5) return mk(OP_DATA, wd, 1'b0);
      return mk(OP_CTRL, lat_val((t < 5) ? t - 1 : t - 6), t >= 9);
    end else if (!bm) begin
      if (t == 1) return mk(OP_SAMP_A, 8'h00, 1'b0);
      if (t == 4) return mk(OP_SAMP_B, 8'h00, 1'b0);
      if (t == 0 || t == 3 || t == 6 || t == 8) return mk(OP_CTRL, 8'h06, 1'b0);
      return mk(OP_CTRL, 8'h04, t >= 9);
    end else begin
      if (t == 0 || t == 3) return mk(OP_CTRL, 8'h26, 1'b0);
      if (t == 1) return mk(OP_SAMP_D, 8'h00, 1'b0);
      return mk(OP_CTRL, 8'h04, t >= 4);
    end
  endfunction

endpackage

// File: rtl/bre_hold_timer.sv
module bre_hold_timer #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic load,
  output logic tick
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= '0;
    else if (run && !tick)   cnt_q <= cnt_q + 1'b1;
  end

  // R8
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= LAST));
endmodule

// File: rtl/bre_seq.sv
module bre_seq
  import bre_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wr,
  input  logic       byte_mode,
  input  logic       cont,
  input  logic [2:0] reg_idx,
  input  logic [7:0] wdata,
  input  logic       tick,
  output logic       run,
  output logic       load,
  output logic [7:0] pc,
  output logic [7:0] pd,
  output logic       samp_a,
  output logic       samp_b,
  output logic       samp_d,
  output logic       done
);
  logic       run_q, wr_q, bm_q, done_q;
  logic [4:0] idx_q;
  logic [7:0] adr_q, wd_q, pc_q, pd_q;
  step_t      first, cur, nxt;
  logic       accept;

  assign first  = step_at(5'd0, wr, byte_mode, addr_byte(cont, reg_idx), wdata);
  assign cur    = step_at(idx_q, wr_q, bm_q, adr_q, wd_q);
  assign nxt    = step_at(idx_q + 5'd1, wr_q, bm_q, adr_q, wd_q);
  assign accept = start && !run_q;
  assign load   = accept || (tick && !cur.last);
  assign samp_a = tick && (cur.op == OP_SAMP_A);
  assign samp_b = tick && (cur.op == OP_SAMP_B);
  assign samp_d = tick && (cur.op == OP_SAMP_D);
  assign run    = run_q;
  assign pc     = pc_q;
  assign pd     = pd_q;
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      wr_q   <= 1'b0;
      bm_q   <= 1'b0;
      adr_q  <= '0;
      wd_q   <= '0;
      pc_q   <= 8'h04;
      pd_q   <= 8'h00;
      done_q <= 1'b0;
    end else begin
      done_q <= tick && cur.last;
      if (accept) begin
        run_q <= 1'b1;
        idx_q <= '0;
        wr_q  <= wr;
        bm_q  <= byte_mode;
        adr_q <= addr_byte(cont, reg_idx);
        wd_q  <= wdata;
        if (first.op == OP_DATA) pd_q <= first.val;
        if (first.op == OP_CTRL) pc_q <= first.val;
      end else if (tick) begin
        if (cur.last) run_q <= 1'b0;
        else begin
          idx_q <= idx_q + 5'd1;
          if (nxt.op == OP_DATA) pd_q <= nxt.val;
          if (nxt.op == OP_CTRL) pc_q <= nxt.val;
        end
      end
    end
  end

  // R8
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick) |=> ($stable(pc_q) && $stable(pd_q)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R2
  ctrl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q inside {8'h04, 8'h05, 8'h06, 8'h07, 8'h0d, 8'h26});
  // R5
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wr_q) |-> !pc_q[5]);
endmodule

// File: rtl/bre_capture.sv
module bre_capture
  import bre_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_a,
  input  logic       samp_b,
  input  logic       samp_d,
  input  logic [7:0] ps_in,
  input  logic [7:0] pd_in,
  output logic [7:0] rd_data
);
  logic [7:0] a_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      rd_q <= '0;
    end else begin
      if (samp_a) a_q <= ps_in;
      if (samp_b) rd_q <= nib_join(a_q, ps_in);
      else if (samp_d) rd_q <= pd_in;
    end
  end

  assign rd_data = rd_q;

  // R6
  one_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({samp_a, samp_b, samp_d}));
endmodule

// File: rtl/bre_engine.sv
module bre_engine #(
  parameter int HOLD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wr,
  input  logic       byte_mode,
  input  logic       cont,
  input  logic [2:0] reg_idx,
  input  logic [7:0] wdata,
  input  logic [7:0] ps_in,
  input  logic [7:0] pd_in,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  output logic [7:0] pc_out,
  output logic [7:0] rd_data,
  output logic       done
);
  logic run_w, load_w, tick_w;
  logic samp_a_w, samp_b_w, samp_d_w;

  bre_hold_timer #(.HOLD(HOLD)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .load(load_w), .tick(tick_w)
  );

  bre_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .byte_mode(byte_mode),
    .cont(cont), .reg_idx(reg_idx), .wdata(wdata), .tick(tick_w),
    .run(run_w), .load(load_w), .pc(pc_out), .pd(pd_out),
    .samp_a(samp_a_w), .samp_b(samp_b_w), .samp_d(samp_d_w), .done(done)
  );

  bre_capture cap_i (
    .clk(clk), .rst_n(rst_n), .samp_a(samp_a_w), .samp_b(samp_b_w),
    .samp_d(samp_d_w), .ps_in(ps_in), .pd_in(pd_in), .rd_data(rd_data)
  );

  assign pd_oe = ~pc_out[5];

  // R9
  idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |=> $stable(rd_data));
  // R8
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run_w));
endmodule

// File: tb/bre_engine_tb_top.sv
module bre_engine_tb_top;
  localparam int HOLD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0, byte_mode = 1'b0, cont = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [7:0] wdata = '0, ps_in = '0, pd_in = '0;
  logic [7:0] pd_out, pc_out, rd_data;
  logic pd_oe, done;

  int checks = 0, errors = 0;
  logic [7:0] e_pc [0:31];
  logic [7:0] e_pd [0:31];
  int ne;
  logic [7:0] m_pc = 8'h04, m_pd = 8'h00, m_rd = 8'h00;

  always #4 clk = ~clk;

  bre_engine #(.HOLD(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .byte_mode(byte_mode),
    .cont(cont), .reg_idx(reg_idx), .wdata(wdata), .ps_in(ps_in), .pd_in(pd_in),
    .pd_out(pd_out), .pd_oe(pd_oe), .pc_out(pc_out), .rd_data(rd_data), .done(done)
  );

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic put();
    e_pc[ne] = m_pc; e_pd[ne] = m_pd; ne++;
  endtask
  task automatic sd(logic [7:0] v); m_pd = v; put(); endtask
  task automatic sc(logic [7:0] v); m_pc = v; put(); endtask
  task automatic sel_hs(); sc(8'h05); sc(8'h0d); sc(8'h05); sc(8'h0d); sc(8'h05); sc(8'h04); endtask
  task automatic lat_hs(); sc(8'h05); sc(8'h07); sc(8'h05); sc(8'h04); endtask

  function automatic string tag_of(int s, logic w, logic b);
    if (s == 7) return "R1 address";
    if (s == 0 || s == 12) return "R4 preamble";
    if (s <= 18) return ((s >= 8 && s <= 11) ? "R3 latch" : "R2 select");
    if (w) return "R5 write tail";
    return b ? "R7 byte read" : "R6 nibble read";
  endfunction

  task automatic run_op(logic w, logic b, logic c, logic [2:0] ix, logic [7:0] wd,
                        logic [7:0] a, logic [7:0] bb, logic [7:0] dv, bit glitch);
    ne = 0;
    sd(8'h01); sel_hs(); sd(8'(int'(ix) * 4 + 1 + int'(c))); lat_hs(); sd(8'h00); sel_hs();
    if (w) begin
      sd(wd); lat_hs(); sd(wd); lat_hs();
    end else if (!b) begin
      sc(8'h06); put(); sc(8'h04); sc(8'h06); put(); sc(8'h04);
      sc(8'h06); sc(8'h04); sc(8'h06); sc(8'h04);
      m_rd = {bb[7:4], a[7:4]};
    end else begin
      sc(8'h26); put(); sc(8'h04); sc(8'h26); sc(8'h04);
      m_rd = dv;
    end
    @(negedge clk);
    wr = w; byte_mode = b; cont = c; reg_idx = ix; wdata = wd;
    ps_in = a; pd_in = dv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < ne; s++) begin
      for (int k = 0; k < HOLD; k++) begin
        if (!w && !b && s == 21 && k == 0) ps_in = bb;
        if (glitch && s == 5 && k == 0) begin
          start = 1'b1; wr = ~w; byte_mode = ~b; reg_idx = ~ix;
        end
        if (glitch && s == 5 && k == 1) start = 1'b0;
        check8(tag_of(s, w, b), pc_out, e_pc[s]);
        check8(tag_of(s, w, b), pd_out, e_pd[s]);
        check8("R7 pd_oe", {7'd0, pd_oe}, {7'd0, ~e_pc[s][5]});
        check8("R8 done early", {7'd0, done}, 8'h00);
        @(negedge clk);
      end
    end
    check8("R8 done timing", {7'd0, done}, 8'h01);
    check8(w ? "R9 write keeps result" : (b ? "R7 result" : "R6 result"), rd_data, m_rd);
    @(negedge clk);
    check8("R8 done single", {7'd0, done}, 8'h00);
  endtask

  task automatic t_reset();
    check8("R10 pc", pc_out, 8'h04);
    check8("R10 pd", pd_out, 8'h00);
    check8("R10 oe", {7'd0, pd_oe}, 8'h01);
    check8("R10 done", {7'd0, done}, 8'h00);
    check8("R10 rd", rd_data, 8'h00);
  endtask

  task automatic t_write_regfile(); run_op(1, 0, 0, 3'd6, 8'ha0, 8'h00, 8'h00, 8'h00, 0); endtask
  task automatic t_write_cmdset(); run_op(1, 1, 1, 3'd7, 8'h5a, 8'h00, 8'h00, 8'h00, 0); endtask
  task automatic t_nibble_read(); run_op(0, 0, 0, 3'd7, 8'h00, 8'hb3, 8'h6c, 8'h00, 0); endtask
  task automatic t_nibble_read2(); run_op(0, 0, 1, 3'd0, 8'h00, 8'hf0, 8'h0f, 8'h00, 0); endtask
  task automatic t_byte_read(); run_op(0, 1, 0, 3'd2, 8'h00, 8'h00, 8'h00, 8'hc7, 0); endtask
  task automatic t_write_after_read(); run_op(1, 0, 1, 3'd1, 8'h3c, 8'h00, 8'h00, 8'h00, 0); endtask
  task automatic t_busy_start(); run_op(0, 0, 0, 3'd5, 8'h00, 8'h9e, 8'h41, 8'h00, 1); endtask

  task automatic t_idle_stable();
    ps_in = 8'h55; pd_in = 8'haa;
    repeat (10) @(negedge clk);
    check8("R9 idle result", rd_data, m_rd);
    check8("R9 idle done", {7'd0, done}, 8'h00);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_regfile();
    t_write_cmdset();
    t_nibble_read();
    t_nibble_read2();
    t_byte_read();
    t_write_after_read();
    t_idle_stable();
    t_busy_start();
    t_idle_stable();
    finish_run();
  end

  initial begin
    #(100000 * 8);
    checks++; errors++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule